// File: doc/BRIEF.md
# Periodic Balancing Command Gate

This block sits behind a CAN controller on a module-level bus and sees every frame that has already been decoded: an 11-bit identifier, eight data bytes and a one-cycle valid strobe. It accepts only the balancing command identifier. From each accepted frame it registers a 16-bit cell bypass threshold code (an offset above a 2.1 V floor), the raw 40-bit bypass function field, and a one-cycle request to start cell-unit ID renumbering.

The block also enforces stream continuity. Commands count only while they keep coming at a steady rate from reset. Once the first command arrives, a gap timer starts. If the timer runs out and a command later shows up, the block moves into a sticky lockout. In lockout it freezes its outputs and drops every further command until the next reset.

The controller has four states. WAIT_FIRST is entered at reset. It accepts any command and moves to STREAMING. STREAMING accepts commands and restarts the timer on each one. When the timer expires it moves to STALLED, or straight to LOCKED if a command arrives on the same edge that the timer is found expired. STALLED accepts nothing and moves to LOCKED on the next command. LOCKED accepts nothing and is left only by reset.

Top module: `bal_cmd_filter`

## Requirements
- R1: Frames whose identifier is not 0x3C3 leave the threshold, bypass field and renumber pulse unchanged.
- R2: Data byte 1 is `frm_data[63:56]` and data byte 2 is `frm_data[55:48]`. On an accepted frame, `thresh_code` becomes {byte 1, byte 2} and appears in the cycle after the frame's valid edge.
- R3: `bypass_field` becomes bytes 4 to 8 (`frm_data[39:0]`) on every accepted frame. An all-zero field, meaning no bypass, overwrites and cancels an earlier non-zero one.
- R4: `renum_pulse` is high for exactly one cycle, the cycle after an accepted frame with bit 2 of byte 4 (`frm_data[34]`) set. It stays low for accepted frames with that bit clear.
- R5: After reset, `thresh_code`, `bypass_field`, `renum_pulse` and `locked_out` are all zero.
- R6: The gap timer runs only after the first accepted frame. Any idle time before that frame causes no lockout.
- R7: A command whose valid edge comes at most GAP_CYCLES clock edges after the previous accepted one is honoured. A command arriving later is ignored and raises `locked_out` from the next cycle.
- R8: `locked_out` stays set until reset. While it is set, commands leave the threshold and bypass field unchanged and produce no renumber pulse.
- R9: A reset clears the lockout, and the first command after it is honoured again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frm_valid | input | 1 | One-cycle strobe for a decoded frame |
| frm_id | input | 11 | Frame identifier |
| frm_data | input | 64 | Data bytes; byte 1 in bits 63:56 |
| thresh_code | output | 16 | Bypass threshold offset code |
| bypass_field | output | 40 | Raw bypass function bytes 4..8 |
| renum_pulse | output | 1 | One-cycle ID renumbering request |
| locked_out | output | 1 | Sticky command lockout status |

## Verification
The bench puts one command at the last permitted spacing and another just one edge past it. A timer that is off by one would lock on the first of these, or would keep accepting commands on the second. It leaves a long idle period before the first command to catch a timer that runs from reset, which would lock a healthy start-up. It sends an all-zero bypass command after a non-zero one to catch a design that treats zero as "leave unchanged". It sends commands after lockout and checks that the outputs stay frozen and that the renumber request stays silent, and it checks that a reset clears the lockout.

// File: rtl/bal_cmd_pkg.sv
package bal_cmd_pkg;

    localparam int ID_W     = 11;
    localparam int DATA_W   = 64;
    localparam int THR_W    = 16;
    localparam int BYP_W    = 40;
    localparam int RENUM_BIT = 34;   // byte 4, bit 2

    typedef enum logic [1:0] {
        WAIT_FIRST = 2'd0,
        STREAMING  = 2'd1,
        STALLED    = 2'd2,
        LOCKED     = 2'd3
    } gate_state_e;

    typedef struct packed {
        logic [THR_W-1:0] thr;
        logic [BYP_W-1:0] byp;
        logic             renum;
    } cmd_fields_t;

endpackage

// File: rtl/bal_frame_match.sv
module bal_frame_match
    import bal_cmd_pkg::*;
#(
    parameter logic [ID_W-1:0] CMD_ID = 11'h3C3
) (
    input  logic              valid,
    input  logic [ID_W-1:0]   id,
    input  logic [DATA_W-1:0] data,
    output logic              hit,
    output cmd_fields_t       fields
);

    logic unused_byte3;

    always_comb begin
        hit          = valid && (id == CMD_ID);
        fields.thr   = data[DATA_W-1 -: THR_W];
        fields.byp   = data[BYP_W-1:0];
        fields.renum = data[RENUM_BIT];
        unused_byte3 = ^data[DATA_W-THR_W-1 -: 8];
    end

endmodule

// File: rtl/bal_gap_timer.sv
module bal_gap_timer #(
    parameter int GAP_CYCLES = 62_500_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic run,
    output logic expired
);

    localparam int CNT_W = $clog2(GAP_CYCLES + 1);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(GAP_CYCLES);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (restart) begin
            cnt_q <= '0;
        end else if (run && cnt_q != LIMIT) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign expired = (cnt_q == LIMIT);

    a_r7_cnt_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LIMIT);

    a_r7_restart_clears: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (cnt_q == '0));

endmodule

// File: rtl/bal_cmd_fsm.sv
module bal_cmd_fsm
    import bal_cmd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hit,
    input  logic expired,
    output logic accept,
    output logic timer_run,
    output logic locked
);

    gate_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= WAIT_FIRST;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WAIT_FIRST: if (hit) state_d = STREAMING;
            STREAMING:  if (expired) state_d = hit ? LOCKED : STALLED;
            STALLED:    if (hit) state_d = LOCKED;
            LOCKED:     state_d = LOCKED;
        endcase
    end

    always_comb begin
        accept    = 1'b0;
        timer_run = 1'b0;
        locked    = 1'b0;
        unique case (state_q)
            WAIT_FIRST: accept = hit;
            STREAMING: begin
                accept    = hit && !expired;
                timer_run = 1'b1;
            end
            STALLED:    accept = 1'b0;
            LOCKED:     locked = 1'b1;
        endcase
    end

    a_r8_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> locked);

    a_r8_no_accept_locked: assert property (@(posedge clk) disable iff (!rst_n)
        locked |-> !accept);

endmodule

// File: rtl/bal_cmd_filter.sv
module bal_cmd_filter
    import bal_cmd_pkg::*;
#(
    parameter logic [ID_W-1:0] CMD_ID     = 11'h3C3,
    parameter int              CLK_HZ     = 125_000_000,
    parameter int              GAP_CYCLES = CLK_HZ / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frm_valid,
    input  logic [ID_W-1:0]   frm_id,
    input  logic [DATA_W-1:0] frm_data,
    output logic [THR_W-1:0]  thresh_code,
    output logic [BYP_W-1:0]  bypass_field,
    output logic              renum_pulse,
    output logic              locked_out
);

    logic        hit, accept, timer_run, expired;
    cmd_fields_t fields;

    bal_frame_match #(.CMD_ID(CMD_ID)) i_match (
        .valid  (frm_valid),
        .id     (frm_id),
        .data   (frm_data),
        .hit    (hit),
        .fields (fields)
    );

    bal_gap_timer #(.GAP_CYCLES(GAP_CYCLES)) i_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (accept),
        .run     (timer_run),
        .expired (expired)
    );

    bal_cmd_fsm i_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .hit       (hit),
        .expired   (expired),
        .accept    (accept),
        .timer_run (timer_run),
        .locked    (locked_out)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            thresh_code  <= '0;
            bypass_field <= '0;
            renum_pulse  <= 1'b0;
        end else begin
            renum_pulse <= accept && fields.renum;
            if (accept) begin
                thresh_code  <= fields.thr;
                bypass_field <= fields.byp;
            end
        end
    end

    a_r1_foreign_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_valid && frm_id != CMD_ID) |=> ($stable(thresh_code) && $stable(bypass_field) && !renum_pulse));

    a_r4_pulse_cause: assert property (@(posedge clk) disable iff (!rst_n)
        renum_pulse |-> $past(frm_valid && frm_id == CMD_ID && frm_data[RENUM_BIT]));

    a_r8_outputs_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        locked_out |=> ($stable(thresh_code) && $stable(bypass_field) && !renum_pulse));

endmodule

// File: tb/test_bal_cmd_filter.sv
module test_bal_cmd_filter;

    localparam int GAP = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frm_valid = 1'b0;
    logic [10:0] frm_id = '0;
    logic [63:0] frm_data = '0;
    logic [15:0] thresh_code;
    logic [39:0] bypass_field;
    logic        renum_pulse;
    logic        locked_out;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    bal_cmd_filter #(.GAP_CYCLES(GAP)) i_bal_cmd_filter (
        .clk(clk), .rst_n(rst_n), .frm_valid(frm_valid), .frm_id(frm_id),
        .frm_data(frm_data), .thresh_code(thresh_code), .bypass_field(bypass_field),
        .renum_pulse(renum_pulse), .locked_out(locked_out)
    );

    function automatic logic [63:0] mk(input logic [15:0] thr, input logic renum, input logic [31:0] tail);
        return {thr, 8'h5A, 5'b0, renum, 2'b0, tail};
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Frame valid for one edge; returns at the negedge after it.
    task automatic send(input logic [10:0] id, input logic [63:0] d);
        @(negedge clk);
        frm_valid = 1'b1; frm_id = id; frm_data = d;
        @(negedge clk);
        frm_valid = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        idle(3);
        rst_n = 1'b1;
    endtask

    task automatic t_reset_state();
        do_reset();
        chk("R5 thresh", 64'(thresh_code), 0);
        chk("R5 bypass", 64'(bypass_field), 0);
        chk("R5 pulse", 64'(renum_pulse), 0);
        chk("R5 lock", 64'(locked_out), 0);
    endtask

    task automatic t_late_first();
        idle(60);
        send(11'h3C3, mk(16'h0123, 1'b0, 32'h1111_2222));
        chk("R6 first after idle", 64'(thresh_code), 64'h0123);
        chk("R6 no lock", 64'(locked_out), 0);
    endtask

    task automatic t_patterns();
        send(11'h3C3, mk(16'hABCD, 1'b0, 32'hDEAD_BEEF));
        chk("R2 thresh", 64'(thresh_code), 64'hABCD);
        chk("R3 bypass", 64'(bypass_field), 64'h00_DEAD_BEEF);
        send(11'h3C3, {16'h0000, 8'h00, 8'hC3, 32'h0000_0001});
        chk("R2 zero thresh", 64'(thresh_code), 0);
        chk("R3 bypass byte4", 64'(bypass_field), 64'hC3_0000_0001);
        chk("R4 byte4 other bits no pulse", 64'(renum_pulse), 0);
        send(11'h3C3, 64'h0);
        chk("R3 zero cancels", 64'(bypass_field), 0);
    endtask

    task automatic t_foreign();
        send(11'h3C3, mk(16'h7777, 1'b0, 32'h5555_0000));
        send(11'h3C4, mk(16'h1234, 1'b1, 32'hFFFF_FFFF));
        chk("R1 thresh kept", 64'(thresh_code), 64'h7777);
        chk("R1 bypass kept", 64'(bypass_field), 64'h00_5555_0000);
        chk("R1 no pulse", 64'(renum_pulse), 0);
        send(11'h1C3, mk(16'h4321, 1'b1, 32'h0));
        chk("R1 thresh kept 2", 64'(thresh_code), 64'h7777);
    endtask

    task automatic t_renum();
        send(11'h3C3, mk(16'h0010, 1'b1, 32'h0));
        chk("R4 pulse high", 64'(renum_pulse), 1);
        chk("R4 bypass has bit", 64'(bypass_field), 64'h04_0000_0000);
        idle(1);
        chk("R4 pulse single", 64'(renum_pulse), 0);
        send(11'h3C3, mk(16'h0011, 1'b0, 32'h0));
        chk("R4 no pulse clear bit", 64'(renum_pulse), 0);
    endtask

    task automatic t_boundary_and_lock();
        send(11'h3C3, mk(16'h0100, 1'b0, 32'h0000_00AA));
        idle(GAP - 2);                       // spacing of exactly GAP edges
        send(11'h3C3, mk(16'h0200, 1'b1, 32'h0000_00BB));
        chk("R7 edge spacing honoured", 64'(thresh_code), 64'h0200);
        chk("R7 edge pulse", 64'(renum_pulse), 1);
        chk("R7 edge no lock", 64'(locked_out), 0);
        idle(GAP - 1);                       // spacing of GAP+1 edges
        send(11'h3C3, mk(16'h0300, 1'b1, 32'h0000_00CC));
        chk("R7 late ignored", 64'(thresh_code), 64'h0200);
        chk("R7 late no pulse", 64'(renum_pulse), 0);
        chk("R7 lock set", 64'(locked_out), 1);
        for (int k = 0; k < 4; k++) begin
            send(11'h3C3, mk(16'h0400, 1'b1, 32'h0));
            chk("R8 pulse suppressed", 64'(renum_pulse), 0);
        end
        chk("R8 thresh frozen", 64'(thresh_code), 64'h0200);
        chk("R8 bypass frozen", 64'(bypass_field), 64'h04_0000_00BB);
        idle(50);
        chk("R8 lock sticky", 64'(locked_out), 1);
    endtask

    task automatic t_stall_then_recover();
        do_reset();
        chk("R9 lock cleared", 64'(locked_out), 0);
        send(11'h3C3, mk(16'h0AAA, 1'b0, 32'h1));
        chk("R9 honoured after reset", 64'(thresh_code), 64'h0AAA);
        idle(3 * GAP);
        chk("R7 stall alone no lock", 64'(locked_out), 0);
        send(11'h3C3, mk(16'h0BBB, 1'b1, 32'h2));
        chk("R7 resume ignored", 64'(thresh_code), 64'h0AAA);
        chk("R8 resume locks", 64'(locked_out), 1);
        do_reset();
        send(11'h3C3, mk(16'h0CCC, 1'b1, 32'h3));
        chk("R9 recovered", 64'(thresh_code), 64'h0CCC);
        chk("R9 pulse", 64'(renum_pulse), 1);
    endtask

    initial begin
        t_reset_state();
        t_late_first();
        t_patterns();
        t_foreign();
        t_renum();
        t_boundary_and_lock();
        t_stall_then_recover();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100_000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule